// File: doc/BRIEF.md
# Programmable Video Data-Enable Generator

This block sits on the pixel clock of a display output path and supplies the data-enable strobe that marks active pixels. It runs in one of two modes. In the first it forwards an external enable input. In the second it builds the enable from the horizontal and vertical sync inputs. To do this it counts pixels since the last line sync and lines since the last frame sync, and opens a rectangular window that is set by a horizontal delay, a vertical top offset, an active pixel count and an active line count.

A narrow write-only register port sets up the block. The mode bit and the two sync polarity bits act at once. The window geometry is held in shadow registers and only reaches the live copy at the next active frame-sync edge, so a frame never shows a mix of old and new geometry. Each counter restarts on the active edge of its sync, taken after polarity normalisation. If a sync goes missing, the counter holds at its maximum rather than wrapping around into a false window.

Top module: `vid_de_gen`

## Requirements
- R1: With the mode bit (control register, address 0, bit 6) at 0, `de_out` equals the `ext_de_in` value sampled one clock earlier.
- R2: With the mode bit at 1, `ext_de_in` has no effect on `de_out`, which carries the generated enable.
- R3: Control bit 4 sets the horizontal sync polarity and control bit 5 sets the vertical sync polarity. A value of 0 means active low and 1 means active high. Both take effect from the clock edge that writes them.
- R4: The line count becomes 0 one clock after the first clock edge that samples the vertical sync active. It grows by one one clock after each edge that first samples the horizontal sync active. When both happen together, the reset wins.
- R5: The pixel count becomes 0 one clock after the first clock edge that samples the horizontal sync active, and otherwise grows by one each clock.
- R6: In generated mode, `de_out` after edge n is 1 exactly when the counts held before edge n satisfy both delay ≤ pixel < delay + active pixels and top ≤ line < top + active lines.
- R7: Register addresses: 0 control (bit 0 is delay bit 8), 1 delay bits 7:0, 2 top offset, 3 and 4 active pixels low byte and high bits, 5 and 6 active lines low byte and high bits. Active counts are 12 bits by default.
- R8: Both counters saturate at their maximum (8191 with default widths) and do not wrap. A long missing line sync therefore never reopens the window.
- R9: Writes to delay, top, active pixels and active lines reach the window only at the next vertical sync restart (R4). Until then the old values stay in use.
- R10: After reset all registers are 0, so the block is in pass-through mode with active-low syncs, and `de_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| hsync_in | input | 1 | Horizontal sync, polarity per control bit 4 |
| vsync_in | input | 1 | Vertical sync, polarity per control bit 5 |
| ext_de_in | input | 1 | External data enable for pass-through mode |
| de_out | output | 1 | Registered data enable |

## Verification
Saturation is the hardest case to reach from the ports. A counter stuck at its ceiling looks, at `de_out`, the same as a counter that is still counting outside the window. The stimulus therefore places the frame inside the vertical window and then holds the line sync idle for more than 2^13 clocks. A wrapping pixel counter would pass through the horizontal window again and raise `de_out`, while a saturating one keeps it low. The deferred geometry update is reached in a similar way. A new active pixel count is written partway through a frame, after the vertical sync has passed, and the lines that follow are checked against the old width until the next frame sync.

// File: rtl/vdg_pkg.sv
package vdg_pkg;
   localparam int DLY_W = 9;
   localparam int TOP_W = 8;

   localparam int CTL_GEN_BIT  = 6;
   localparam int CTL_VPOL_BIT = 5;
   localparam int CTL_HPOL_BIT = 4;
   localparam int CTL_DMSB_BIT = 0;

   typedef enum logic [2:0] {
      A_CTRL    = 3'd0,
      A_DLY_LO  = 3'd1,
      A_TOP     = 3'd2,
      A_HACT_LO = 3'd3,
      A_HACT_HI = 3'd4,
      A_VACT_LO = 3'd5,
      A_VACT_HI = 3'd6
   } vdg_addr_e;
endpackage

// File: rtl/vdg_regs.sv
module vdg_regs
   import vdg_pkg::*;
#(
   parameter int H_ACT_W = 12,
   parameter int V_ACT_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [2:0]         addr,
   input  logic [7:0]         wdata,
   input  logic               commit,
   output logic               gen_en,
   output logic               hpol,
   output logic               vpol,
   output logic [DLY_W-1:0]   act_dly,
   output logic [TOP_W-1:0]   act_top,
   output logic [H_ACT_W-1:0] act_hact,
   output logic [V_ACT_W-1:0] act_vact
);
   localparam int H_HI_W = H_ACT_W - 8;
   localparam int V_HI_W = V_ACT_W - 8;

   logic [DLY_W-1:0]   sh_dly;
   logic [TOP_W-1:0]   sh_top;
   logic [H_ACT_W-1:0] sh_hact;
   logic [V_ACT_W-1:0] sh_vact;

   // reserved control bits carry no state
   logic unused_rsvd;
   assign unused_rsvd = ^{wdata[7], wdata[3:1]};

   generate
      if (H_HI_W < 8) begin : g_hhi_part
         logic unused_hhi;
         assign unused_hhi = ^wdata[7:H_HI_W];
      end
      if (V_HI_W < 8) begin : g_vhi_part
         logic unused_vhi;
         assign unused_vhi = ^wdata[7:V_HI_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en  <= 1'b0;
         hpol    <= 1'b0;
         vpol    <= 1'b0;
         sh_dly  <= '0;
         sh_top  <= '0;
         sh_hact <= '0;
         sh_vact <= '0;
      end else if (we) begin
         case (addr)
            A_CTRL: begin
               gen_en          <= wdata[CTL_GEN_BIT];
               vpol            <= wdata[CTL_VPOL_BIT];
               hpol            <= wdata[CTL_HPOL_BIT];
               sh_dly[DLY_W-1] <= wdata[CTL_DMSB_BIT];
            end
            A_DLY_LO:  sh_dly[7:0]           <= wdata;
            A_TOP:     sh_top                <= wdata;
            A_HACT_LO: sh_hact[7:0]          <= wdata;
            A_HACT_HI: sh_hact[H_ACT_W-1:8]  <= wdata[H_HI_W-1:0];
            A_VACT_LO: sh_vact[7:0]          <= wdata;
            A_VACT_HI: sh_vact[V_ACT_W-1:8]  <= wdata[V_HI_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_dly  <= '0;
         act_top  <= '0;
         act_hact <= '0;
         act_vact <= '0;
      end else if (commit) begin
         act_dly  <= sh_dly;
         act_top  <= sh_top;
         act_hact <= sh_hact;
         act_vact <= sh_vact;
      end
   end
endmodule

// File: rtl/vdg_sync_edge.sv
module vdg_sync_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic pol,
   output logic rise
);
   logic s_cur, s_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_cur  <= 1'b0;
         s_prev <= 1'b0;
      end else begin
         s_cur  <= pol ? sync_in : ~sync_in;
         s_prev <= s_cur;
      end
   end

   assign rise = s_cur & ~s_prev;
endmodule

// File: rtl/vdg_sat_cnt.sv
module vdg_sat_cnt #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CMAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (inc && cnt != CMAX)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/vid_de_gen.sv
module vid_de_gen
   import vdg_pkg::*;
#(
   parameter int H_ACT_W = 12,
   parameter int V_ACT_W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [2:0] cfg_addr,
   input  logic [7:0] cfg_wdata,
   input  logic       hsync_in,
   input  logic       vsync_in,
   input  logic       ext_de_in,
   output logic       de_out
);
   localparam int PIX_W = ((H_ACT_W > DLY_W) ? H_ACT_W : DLY_W) + 1;
   localparam int LIN_W = ((V_ACT_W > TOP_W) ? V_ACT_W : TOP_W) + 1;
   localparam int N_SYNC = 2;

   generate
      if (H_ACT_W < 9 || H_ACT_W > 16) begin : g_bad_h
         $error("H_ACT_W must lie in 9..16");
      end
      if (V_ACT_W < 9 || V_ACT_W > 16) begin : g_bad_v
         $error("V_ACT_W must lie in 9..16");
      end
   endgenerate

   logic               gen_en, hpol, vpol;
   logic [DLY_W-1:0]   act_dly;
   logic [TOP_W-1:0]   act_top;
   logic [H_ACT_W-1:0] act_hact;
   logic [V_ACT_W-1:0] act_vact;
   logic               hs_rise, vs_rise;
   logic [PIX_W-1:0]   pix_cnt;
   logic [LIN_W-1:0]   lin_cnt;

   vdg_regs #(.H_ACT_W(H_ACT_W), .V_ACT_W(V_ACT_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .commit(vs_rise), .gen_en(gen_en),
      .hpol(hpol), .vpol(vpol), .act_dly(act_dly), .act_top(act_top),
      .act_hact(act_hact), .act_vact(act_vact)
   );

   // index 0: line sync, index 1: frame sync
   logic [N_SYNC-1:0] sync_v, pol_v, rise_v;
   assign sync_v = {vsync_in, hsync_in};
   assign pol_v  = {vpol, hpol};

   generate
      for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_edge
         vdg_sync_edge i_edge (
            .clk(clk), .rst_n(rst_n), .sync_in(sync_v[gi]),
            .pol(pol_v[gi]), .rise(rise_v[gi])
         );
      end
   endgenerate

   assign hs_rise = rise_v[0];
   assign vs_rise = rise_v[1];

   vdg_sat_cnt #(.W(PIX_W)) i_pix (
      .clk(clk), .rst_n(rst_n), .clr(hs_rise), .inc(1'b1), .cnt(pix_cnt)
   );

   vdg_sat_cnt #(.W(LIN_W)) i_lin (
      .clk(clk), .rst_n(rst_n), .clr(vs_rise), .inc(hs_rise), .cnt(lin_cnt)
   );

   logic [PIX_W-1:0] h_lo, h_hi;
   logic [LIN_W-1:0] v_lo, v_hi;
   logic             in_win;

   always_comb begin
      h_lo   = PIX_W'(act_dly);
      h_hi   = PIX_W'(act_dly) + PIX_W'(act_hact);
      v_lo   = LIN_W'(act_top);
      v_hi   = LIN_W'(act_top) + LIN_W'(act_vact);
      in_win = (pix_cnt >= h_lo) && (pix_cnt < h_hi) &&
               (lin_cnt >= v_lo) && (lin_cnt < v_hi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) de_out <= 1'b0;
      else        de_out <= gen_en ? in_win : ext_de_in;
   end
endmodule

// File: rtl/vdg_checker.sv
module vdg_checker #(
   parameter int PIX_W   = 13,
   parameter int LIN_W   = 13,
   parameter int DLY_W   = 9,
   parameter int TOP_W   = 8,
   parameter int H_ACT_W = 12,
   parameter int V_ACT_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               gen_en,
   input logic               ext_de_in,
   input logic               de_out,
   input logic               hs_rise,
   input logic               vs_rise,
   input logic [PIX_W-1:0]   pix_cnt,
   input logic [LIN_W-1:0]   lin_cnt,
   input logic [DLY_W-1:0]   act_dly,
   input logic [TOP_W-1:0]   act_top,
   input logic [H_ACT_W-1:0] act_hact,
   input logic [V_ACT_W-1:0] act_vact
);
   localparam logic [PIX_W-1:0] PMAX = '1;

   assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> (de_out == $past(ext_de_in)));

   assert_before_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && pix_cnt < PIX_W'(act_dly)) |=> !de_out);

   assert_line_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> (lin_cnt == '0));

   assert_pix_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hs_rise |=> (pix_cnt == '0));

   assert_pix_hold_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_cnt == PMAX && !hs_rise) |=> (pix_cnt == PMAX));

   assert_geom_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_rise |=> $stable({act_dly, act_top, act_hact, act_vact}));
endmodule

bind vid_de_gen vdg_checker #(
   .PIX_W(PIX_W), .LIN_W(LIN_W), .DLY_W(vdg_pkg::DLY_W), .TOP_W(vdg_pkg::TOP_W),
   .H_ACT_W(H_ACT_W), .V_ACT_W(V_ACT_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .ext_de_in(ext_de_in),
   .de_out(de_out), .hs_rise(hs_rise), .vs_rise(vs_rise),
   .pix_cnt(pix_cnt), .lin_cnt(lin_cnt), .act_dly(act_dly),
   .act_top(act_top), .act_hact(act_hact), .act_vact(act_vact)
);

// File: tb/test_vid_de_gen.sv
module test_vid_de_gen;
   localparam int CNT_MAX = 8191;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       hsync_in = 1'b1;
   logic       vsync_in = 1'b1;
   logic       ext_de_in = 1'b0;
   logic       de_out;

   always #4 clk = ~clk;

   vid_de_gen i_vid_de_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .hsync_in(hsync_in), .vsync_in(vsync_in),
      .ext_de_in(ext_de_in), .de_out(de_out)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   string cur_req = "R10";
   bit    exp_q[$];
   logic [15:0] lfsr = 16'hACE1;

   // requirement-level model state
   bit m_gen, m_hpol, m_vpol;
   int m_dly, m_top, m_hact, m_vact;
   int s_dly, s_top, s_hact, s_vact;
   int m_pix, m_lin;
   bit m_hprev, m_vprev, m_hpend, m_vpend;

   task automatic step(input bit h, input bit v, input bit e,
                       input bit we = 1'b0, input bit [2:0] a = 3'd0,
                       input bit [7:0] d = 8'd0);
      bit exp_de, hn, vn;
      hsync_in = h; vsync_in = v; ext_de_in = e;
      cfg_we = we; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      exp_de = m_gen ? (m_pix >= m_dly && m_pix < m_dly + m_hact &&
                        m_lin >= m_top && m_lin < m_top + m_vact) : e;
      exp_q.push_back(exp_de);
      if (m_vpend) m_lin = 0;
      else if (m_hpend && m_lin < CNT_MAX) m_lin++;
      if (m_hpend) m_pix = 0;
      else if (m_pix < CNT_MAX) m_pix++;
      if (m_vpend) begin
         m_dly = s_dly; m_top = s_top; m_hact = s_hact; m_vact = s_vact;
      end
      hn = m_hpol ? h : !h;
      vn = m_vpol ? v : !v;
      m_hpend = hn && !m_hprev; m_hprev = hn;
      m_vpend = vn && !m_vprev; m_vprev = vn;
      if (we) begin
         case (a)
            3'd0: begin
               m_gen = d[6]; m_vpol = d[5]; m_hpol = d[4];
               s_dly = (s_dly & 255) | (int'(d[0]) << 8);
            end
            3'd1: s_dly = (s_dly & 256) | int'(d);
            3'd2: s_top = int'(d);
            3'd3: s_hact = (s_hact & 32'hF00) | int'(d);
            3'd4: s_hact = (s_hact & 255) | (int'(d[3:0]) << 8);
            3'd5: s_vact = (s_vact & 32'hF00) | int'(d);
            3'd6: s_vact = (s_vact & 255) | (int'(d[3:0]) << 8);
            default: ;
         endcase
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic bit rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic wr(input bit [2:0] a, input bit [7:0] d);
      step(!m_hpol, !m_vpol, rnd(), 1'b1, a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(!m_hpol, !m_vpol, rnd());
   endtask

   // nl lines of len clocks, line sync width hw, frame sync over the first vl lines
   task automatic frame(input int nl, input int len, input int hw, input int vl);
      for (int l = 0; l < nl; l++)
         for (int k = 0; k < len; k++)
            step((k < hw) ? m_hpol : !m_hpol, (l < vl) ? m_vpol : !m_vpol, rnd());
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done && exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         n_checks++;
         if (de_out !== e) begin
            n_errors++;
            $display("FAIL %s: de_out=%0b expected %0b at %0t", cur_req, de_out, e, $time);
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      n_checks++;
      if (de_out !== 1'b0) begin
         n_errors++;
         $display("FAIL R10: de_out=%0b expected 0", de_out);
      end

      cur_req = "R1 pass-through";
      idle(60);

      cur_req = "R7 R9 setup";
      wr(3'd0, 8'h40);
      wr(3'd1, 8'd5);
      wr(3'd2, 8'd2);
      wr(3'd3, 8'd10);
      wr(3'd4, 8'd0);
      wr(3'd5, 8'd3);
      wr(3'd6, 8'd0);

      cur_req = "R2 R4 R5 R6 generated";
      repeat (3) frame(8, 40, 4, 1);

      cur_req = "R9 deferred update";
      frame(4, 40, 4, 1);
      wr(3'd3, 8'd20);
      frame(4, 40, 4, 0);
      frame(8, 40, 4, 1);

      cur_req = "R3 active-high syncs";
      wr(3'd0, 8'h70);
      repeat (2) frame(8, 40, 4, 1);

      cur_req = "R3 mixed polarity";
      wr(3'd0, 8'h60);
      repeat (2) frame(8, 40, 6, 2);

      cur_req = "R7 delay bit 8";
      wr(3'd0, 8'h61);
      wr(3'd1, 8'd3);
      wr(3'd4, 8'h01);
      wr(3'd3, 8'h02);
      repeat (2) frame(6, 300, 4, 1);

      cur_req = "R8 saturation";
      wr(3'd0, 8'h60);
      wr(3'd1, 8'd5);
      wr(3'd4, 8'h00);
      wr(3'd3, 8'd10);
      frame(3, 40, 4, 1);
      idle(9000);

      cur_req = "R1 back to pass-through";
      wr(3'd0, 8'h00);
      idle(80);

      @(negedge clk);
      finish_run();
   end
endmodule